// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to a small 16-bit segmented processor core and carries out the hardware part of taking an interrupt. The core strobes `boundary` each time an instruction has fully retired. On that strobe the block checks two request lines. One is a non-maskable line with its own fixed vector. The other is a maskable line, which is honoured only while the core's interrupt-enable flag is set. When a request wins, the block owns the memory port until the entry is complete.

For a maskable request the block first runs two acknowledge handshakes with an external interrupt controller and takes the 8-bit vector type from the second one. It then saves the return context on the stack as three word writes, each placed at a pre-decremented stack pointer. Next it reads the new instruction pointer and code segment from the vector slot at type×4 in low memory. Finally it gives the core one cycle of load strobes that install the new segment, pointer and stack pointer and clear the interrupt-enable and trap flags.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry begins only in the cycle after a clock edge at which `boundary` was high and a request was eligible. With no eligible request, or with no boundary strobe, `busy` stays low.
- R2: A pending non-maskable request wins over a maskable one, uses vector type 2 and runs no acknowledge handshake.
- R3: The maskable request is taken only when `ie_flag` is 1 at the boundary. It is level-sensitive and is sampled again at every boundary.
- R4: A maskable entry raises `iack_req` for two separate handshakes, with `iack_req` low for at least one cycle between them. Each handshake completes on `iack_rdy`. The vector type is the `iack_data` value present at the completion of the second handshake. `iack_req` and `mem_req` are never high together.
- R5: The stack save is three writes (`mem_we`=1), in this order: flags, return CS, return IP. Before each write the stack pointer is lowered by 2, modulo 2^16. Each write address is SS×16 + SP, modulo 2^20.
- R6: The new IP is the word read from address type×4, and the new CS is the word read from type×4+2. Every read the block makes therefore lies below address 0x400 and is even.
- R7: Entry ends with `done` high for exactly one cycle. In that cycle `ip_load`, `cs_load`, `sp_load` and `flag_clr` are all high, `ip_val`/`cs_val` hold the words that were read, and `sp_val` equals the starting SP minus 6.
- R8: Each memory access holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until a cycle with `mem_ack` high. A stall of any length only delays the sequence.
- R9: The non-maskable input is taken on its rising edge and stays pending until it is serviced. A level held high is serviced once. An edge that arrives during an entry is serviced at a later boundary.
- R10: While `busy` is high, neither `boundary` nor a request starts, restarts or shortens the sequence in progress.
- R11: Synchronous active-high `rst` returns the block to idle, drops every request and strobe, and discards a pending non-maskable request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boundary | input | 1 | Instruction-retired strobe from the core |
| nmi_in | input | 1 | Non-maskable request, edge-triggered |
| intr_in | input | 1 | Maskable request, level |
| ie_flag | input | 1 | Core interrupt-enable flag |
| flags_in | input | 16 | Core flag word to save |
| cs_in | input | 16 | Return code segment |
| ip_in | input | 16 | Return instruction pointer |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer before entry |
| iack_req | output | 1 | Acknowledge handshake request to the controller |
| iack_rdy | input | 1 | Controller completes a handshake |
| iack_data | input | 8 | Vector type from the controller |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | An entry sequence is in progress |
| done | output | 1 | One-cycle end-of-entry pulse |
| ip_load | output | 1 | Load `ip_val` into IP |
| cs_load | output | 1 | Load `cs_val` into CS |
| sp_load | output | 1 | Load `sp_val` into SP |
| flag_clr | output | 1 | Clear interrupt-enable and trap flags |
| ip_val | output | 16 | New instruction pointer |
| cs_val | output | 16 | New code segment |
| sp_val | output | 16 | Stack pointer after the saves |

## Verification
The bench attacks priority and the acknowledge pair. It drives a decoy value on the first handshake, so a design that latched the vector too early would read the wrong slot, and a design that skipped the pair or took the wrong line when both request at once would show up in the vector and in the handshake count. Stack pointers near zero and segments near the top of memory check the 16-bit and 20-bit wrap; an adder of the wrong width or a push after the write instead of before would place the saved words at the wrong addresses. The remaining stimuli cover memory stalls, a held non-maskable level, an edge and a boundary that arrive during an entry, and a reset part way through a save. A design that latched a level, lost a pending edge, restarted mid-sequence or kept stale state after reset would produce an extra or missing entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int WORD_W    = 16;
    localparam int PADDR_W   = 20;
    localparam int VTYPE_W   = 8;
    localparam int SEG_SHIFT = 4;
    localparam int SLOT_LOG2 = 2;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [PADDR_W-1:0] paddr_t;
    typedef logic [VTYPE_W-1:0] vtype_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK_A,
        ST_ACK_GAP,
        ST_ACK_B,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VEC_IP,
        ST_VEC_CS,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        word_t flags;
        word_t cs;
        word_t ip;
        word_t ss;
    } ctx_t;

    typedef struct packed {
        logic   req;
        logic   we;
        paddr_t addr;
        word_t  wdata;
    } bus_req_t;

    function automatic paddr_t phys(input word_t seg, input word_t off);
        return (paddr_t'(seg) << SEG_SHIFT) + paddr_t'(off);
    endfunction

    function automatic paddr_t vec_slot(input vtype_t t, input logic hi);
        return (paddr_t'(t) << SLOT_LOG2) + (hi ? paddr_t'(2) : paddr_t'(0));
    endfunction

    function automatic word_t pre_dec(input word_t sp);
        return sp - word_t'(2);
    endfunction

    function automatic logic is_push(input seq_state_e s);
        return (s == ST_PUSH_FL) || (s == ST_PUSH_CS) || (s == ST_PUSH_IP);
    endfunction

endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb
    import irq_entry_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic boundary,
    input  logic busy,
    input  logic nmi_in,
    input  logic intr_in,
    input  logic ie_flag,
    output logic take,
    output logic take_nmi
);

    logic nmi_q;
    logic nmi_pend;
    logic nmi_rise;

    assign nmi_rise = nmi_in & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_in;
            nmi_pend <= (nmi_pend & ~(take & take_nmi)) | nmi_rise;
        end
    end

    always_comb begin
        take_nmi = nmi_pend;
        take     = boundary & ~busy & (nmi_pend | (intr_in & ie_flag));
    end

    // R9
    nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !take) |=> nmi_pend);

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !nmi_pend) |-> (intr_in && ie_flag));

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int NMI_VEC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       take_nmi,
    input  ctx_t       ctx_in,
    input  word_t      sp_in,
    input  logic       mem_ack,
    input  word_t      mem_rdata,
    input  logic       iack_rdy,
    input  vtype_t     iack_data,
    output seq_state_e state,
    output ctx_t       ctx_q,
    output word_t      sp_cur,
    output vtype_t     vtype,
    output word_t      new_ip,
    output word_t      new_cs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctx_q  <= '0;
            sp_cur <= '0;
            vtype  <= '0;
            new_ip <= '0;
            new_cs <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        ctx_q  <= ctx_in;
                        sp_cur <= sp_in;
                        vtype  <= vtype_t'(NMI_VEC);
                        state  <= take_nmi ? ST_PUSH_FL : ST_ACK_A;
                    end
                end
                ST_ACK_A: begin
                    if (iack_rdy) state <= ST_ACK_GAP;
                end
                ST_ACK_GAP: begin
                    state <= ST_ACK_B;
                end
                ST_ACK_B: begin
                    if (iack_rdy) begin
                        vtype <= iack_data;
                        state <= ST_PUSH_FL;
                    end
                end
                ST_PUSH_FL: begin
                    if (mem_ack) begin
                        sp_cur <= pre_dec(sp_cur);
                        state  <= ST_PUSH_CS;
                    end
                end
                ST_PUSH_CS: begin
                    if (mem_ack) begin
                        sp_cur <= pre_dec(sp_cur);
                        state  <= ST_PUSH_IP;
                    end
                end
                ST_PUSH_IP: begin
                    if (mem_ack) begin
                        sp_cur <= pre_dec(sp_cur);
                        state  <= ST_VEC_IP;
                    end
                end
                ST_VEC_IP: begin
                    if (mem_ack) begin
                        new_ip <= mem_rdata;
                        state  <= ST_VEC_CS;
                    end
                end
                ST_VEC_CS: begin
                    if (mem_ack) begin
                        new_cs <= mem_rdata;
                        state  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));

    // R4
    gap_between_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK_A && iack_rdy) |=> (state == ST_ACK_GAP));

endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux
    import irq_entry_pkg::*;
(
    input  seq_state_e state,
    input  ctx_t       ctx_q,
    input  word_t      sp_cur,
    input  vtype_t     vtype,
    output bus_req_t   bus,
    output logic       iack_req
);

    paddr_t push_addr;

    always_comb begin
        push_addr = phys(ctx_q.ss, pre_dec(sp_cur));
        bus       = '0;
        iack_req  = (state == ST_ACK_A) || (state == ST_ACK_B);
        case (state)
            ST_PUSH_FL: bus = '{req: 1'b1, we: 1'b1, addr: push_addr, wdata: ctx_q.flags};
            ST_PUSH_CS: bus = '{req: 1'b1, we: 1'b1, addr: push_addr, wdata: ctx_q.cs};
            ST_PUSH_IP: bus = '{req: 1'b1, we: 1'b1, addr: push_addr, wdata: ctx_q.ip};
            ST_VEC_IP:  bus = '{req: 1'b1, we: 1'b0, addr: vec_slot(vtype, 1'b0), wdata: '0};
            ST_VEC_CS:  bus = '{req: 1'b1, we: 1'b0, addr: vec_slot(vtype, 1'b1), wdata: '0};
            default:    bus = '0;
        endcase
    end

    // R5
    always_comb begin
        if (is_push(state)) begin
            push_we_chk: assert (bus.req && bus.we);
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NMI_VEC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  logic        nmi_in,
    input  logic        intr_in,
    input  logic        ie_flag,
    input  logic [15:0] flags_in,
    input  logic [15:0] cs_in,
    input  logic [15:0] ip_in,
    input  logic [15:0] ss_in,
    input  logic [15:0] sp_in,
    output logic        iack_req,
    input  logic        iack_rdy,
    input  logic [7:0]  iack_data,
    output logic        mem_req,
    output logic        mem_we,
    output logic [19:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        ip_load,
    output logic        cs_load,
    output logic        sp_load,
    output logic        flag_clr,
    output logic [15:0] ip_val,
    output logic [15:0] cs_val,
    output logic [15:0] sp_val
);

    logic       take;
    logic       take_nmi;
    seq_state_e state;
    ctx_t       ctx_in;
    ctx_t       ctx_q;
    word_t      sp_cur;
    vtype_t     vtype;
    word_t      new_ip;
    word_t      new_cs;
    bus_req_t   bus;

    assign ctx_in = '{flags: flags_in, cs: cs_in, ip: ip_in, ss: ss_in};

    irq_req_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .busy     (busy),
        .nmi_in   (nmi_in),
        .intr_in  (intr_in),
        .ie_flag  (ie_flag),
        .take     (take),
        .take_nmi (take_nmi)
    );

    irq_entry_fsm #(.NMI_VEC(NMI_VEC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_nmi  (take_nmi),
        .ctx_in    (ctx_in),
        .sp_in     (sp_in),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .iack_rdy  (iack_rdy),
        .iack_data (iack_data),
        .state     (state),
        .ctx_q     (ctx_q),
        .sp_cur    (sp_cur),
        .vtype     (vtype),
        .new_ip    (new_ip),
        .new_cs    (new_cs)
    );

    irq_bus_mux u_mux (
        .state    (state),
        .ctx_q    (ctx_q),
        .sp_cur   (sp_cur),
        .vtype    (vtype),
        .bus      (bus),
        .iack_req (iack_req)
    );

    always_comb begin
        mem_req   = bus.req;
        mem_we    = bus.we;
        mem_addr  = bus.addr;
        mem_wdata = bus.wdata;
        busy      = (state != ST_IDLE);
        done      = (state == ST_LOAD);
        ip_load   = done;
        cs_load   = done;
        sp_load   = done;
        flag_clr  = done;
        ip_val    = new_ip;
        cs_val    = new_cs;
        sp_val    = sp_cur;
    end

    // R1
    start_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy)) |-> $past(boundary));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(iack_req && mem_req));

    // R6
    vec_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr[19:10] == '0 && !mem_addr[0]));

    // R10
    no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary = 1'b0;
    logic        nmi_in = 1'b0;
    logic        intr_in = 1'b0;
    logic        ie_flag = 1'b0;
    logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
    logic        iack_req, iack_rdy = 1'b0;
    logic [7:0]  iack_data = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        busy, done, ip_load, cs_load, sp_load, flag_clr;
    logic [15:0] ip_val, cs_val, sp_val;

    always #2.5 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .boundary(boundary), .nmi_in(nmi_in), .intr_in(intr_in),
        .ie_flag(ie_flag), .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in),
        .sp_in(sp_in), .iack_req(iack_req), .iack_rdy(iack_rdy), .iack_data(iack_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .ip_load(ip_load), .cs_load(cs_load), .sp_load(sp_load), .flag_clr(flag_clr),
        .ip_val(ip_val), .cs_val(cs_val), .sp_val(sp_val)
    );

    int n_chk = 0;
    int n_err = 0;

    function automatic logic [15:0] rd_model(input logic [19:0] a);
        return a[15:0] ^ 16'h3C5A ^ {12'h0, a[19:16]};
    endfunction

    // memory responder with programmable stall; logs writes
    int          mem_dly = 0;
    int          mem_wait = 0;
    int          wr_total = 0;
    logic [19:0] wr_addr [64];
    logic [15:0] wr_data [64];
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack  <= 1'b0;
            mem_wait <= 0;
        end else if (mem_req) begin
            if (mem_wait >= mem_dly) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd_model(mem_addr);
                if (mem_we) begin
                    wr_addr[wr_total % 64] <= mem_addr;
                    wr_data[wr_total % 64] <= mem_wdata;
                    wr_total <= wr_total + 1;
                end
            end else begin
                mem_wait <= mem_wait + 1;
            end
        end
    end

    // controller responder: decoy on first handshake of a pair
    logic [7:0] cfg_vec = '0;
    int         iack_total = 0;
    always @(negedge clk) begin
        if (iack_rdy) begin
            iack_rdy <= 1'b0;
        end else if (iack_req) begin
            iack_rdy   <= 1'b1;
            iack_data  <= (iack_total % 2 == 0) ? ~cfg_vec : cfg_vec;
            iack_total <= iack_total + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_boundary();
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
    endtask

    task automatic pulse_nmi();
        @(negedge clk) nmi_in = 1'b1;
        @(negedge clk) nmi_in = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'b0, done}, 32'd1);
    endtask

    function automatic logic [19:0] stack_addr(input logic [15:0] ss, input logic [15:0] sp, input int k);
        logic [15:0] off;
        off = sp - 16'(2 * k);
        return ({4'h0, ss} << 4) + {4'h0, off};
    endfunction

    // checks at the done cycle: loads, vector words and the three saves
    task automatic check_entry(input logic [7:0] vec, input logic [15:0] ss, input logic [15:0] sp,
                               input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                               input int wr_base, input int ack_base, input int exp_acks);
        chk("R6 ip", {16'h0, ip_val}, {16'h0, rd_model({10'h0, vec, 2'b00})});
        chk("R6 cs", {16'h0, cs_val}, {16'h0, rd_model({10'h0, vec, 2'b10})});
        chk("R7 sp", {16'h0, sp_val}, {16'h0, sp - 16'd6});
        chk("R7 strobes", {28'h0, ip_load, cs_load, sp_load, flag_clr}, 32'hF);
        chk("R4 handshakes", 32'(iack_total - ack_base), 32'(exp_acks));
        chk("R5 count", 32'(wr_total - wr_base), 32'd3);
        chk("R5 flags addr", {12'h0, wr_addr[wr_base % 64]}, {12'h0, stack_addr(ss, sp, 1)});
        chk("R5 flags data", {16'h0, wr_data[wr_base % 64]}, {16'h0, fl});
        chk("R5 cs addr", {12'h0, wr_addr[(wr_base + 1) % 64]}, {12'h0, stack_addr(ss, sp, 2)});
        chk("R5 cs data", {16'h0, wr_data[(wr_base + 1) % 64]}, {16'h0, cs});
        chk("R5 ip addr", {12'h0, wr_addr[(wr_base + 2) % 64]}, {12'h0, stack_addr(ss, sp, 3)});
        chk("R5 ip data", {16'h0, wr_data[(wr_base + 2) % 64]}, {16'h0, ip});
        @(negedge clk);
        chk("R7 done width", {31'b0, done}, 32'd0);
    endtask

    typedef struct packed {
        logic        nmi;
        logic        intr;
        logic        ie;
        logic [7:0]  vec;
        logic [15:0] ss;
        logic [15:0] sp;
        logic [1:0]  dly;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TABLE [NV] = '{
        '{nmi: 1'b1, intr: 1'b0, ie: 1'b0, vec: 8'h55, ss: 16'h2000, sp: 16'h1000, dly: 2'd0},
        '{nmi: 1'b0, intr: 1'b1, ie: 1'b1, vec: 8'h08, ss: 16'h0030, sp: 16'h0100, dly: 2'd0},
        '{nmi: 1'b0, intr: 1'b1, ie: 1'b1, vec: 8'hFF, ss: 16'hF000, sp: 16'h0004, dly: 2'd1},
        '{nmi: 1'b1, intr: 1'b1, ie: 1'b1, vec: 8'h33, ss: 16'h0400, sp: 16'h0800, dly: 2'd0},
        '{nmi: 1'b0, intr: 1'b1, ie: 1'b1, vec: 8'h00, ss: 16'h1234, sp: 16'h8000, dly: 2'd3},
        '{nmi: 1'b0, intr: 1'b1, ie: 1'b1, vec: 8'h21, ss: 16'hFFFF, sp: 16'hFFFE, dly: 2'd2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int wb, ab;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", {31'b0, busy}, 32'd0);
        chk("R11 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R11 iack_req", {31'b0, iack_req}, 32'd0);
        chk("R11 done", {31'b0, done}, 32'd0);
        @(negedge clk) rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            flags_in = 16'h0300 | 16'(i);
            cs_in    = 16'hC000 + 16'(i * 16'h111);
            ip_in    = 16'h1000 + 16'(i * 16'h0202);
            ss_in    = TABLE[i].ss;
            sp_in    = TABLE[i].sp;
            cfg_vec  = TABLE[i].vec;
            mem_dly  = int'(TABLE[i].dly);
            intr_in  = TABLE[i].intr;
            ie_flag  = TABLE[i].ie;
            wb = wr_total;
            ab = iack_total;
            if (TABLE[i].nmi) pulse_nmi();
            pulse_boundary();
            chk("R1 busy after boundary", {31'b0, busy}, 32'd1);
            intr_in = 1'b0;
            wait_done("R1 completes");
            // R2: non-maskable wins, type 2, no handshake
            check_entry(TABLE[i].nmi ? 8'h02 : TABLE[i].vec, TABLE[i].ss, TABLE[i].sp,
                        16'h0300 | 16'(i), 16'hC000 + 16'(i * 16'h111), 16'h1000 + 16'(i * 16'h0202),
                        wb, ab, TABLE[i].nmi ? 0 : 2);
        end
        mem_dly = 0;

        // R1: request without boundary does nothing
        intr_in = 1'b1; ie_flag = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 no boundary", {31'b0, busy}, 32'd0);
        intr_in = 1'b0;

        // R1: boundary with no request does nothing
        pulse_boundary();
        chk("R1 no request", {31'b0, busy}, 32'd0);

        // R3: masked request ignored
        intr_in = 1'b1; ie_flag = 1'b0;
        wb = wr_total;
        pulse_boundary();
        chk("R3 masked busy", {31'b0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R3 masked iack", {31'b0, iack_req}, 32'd0);
        chk("R3 masked writes", 32'(wr_total - wb), 32'd0);
        intr_in = 1'b0;

        // R9: held level serviced once
        ss_in = 16'h0100; sp_in = 16'h0200;
        nmi_in = 1'b1;
        @(negedge clk);
        pulse_boundary();
        wait_done("R9 held entry");
        chk("R9 held vector", {16'h0, ip_val}, {16'h0, rd_model(20'h00008)});
        repeat (2) @(negedge clk);
        pulse_boundary();
        chk("R9 held once", {31'b0, busy}, 32'd0);
        nmi_in = 1'b0;

        // R10 + R9: edge and boundary during an entry
        cfg_vec = 8'h40; intr_in = 1'b1; ie_flag = 1'b1; mem_dly = 2;
        wb = wr_total; ab = iack_total;
        pulse_boundary();
        intr_in = 1'b0;
        pulse_nmi();
        pulse_boundary();
        wait_done("R10 first entry");
        chk("R10 vector kept", {16'h0, ip_val}, {16'h0, rd_model(20'h00100)});
        chk("R10 single save", 32'(wr_total - wb), 32'd3);
        chk("R10 handshakes", 32'(iack_total - ab), 32'd2);
        repeat (2) @(negedge clk);
        chk("R10 no restart", {31'b0, busy}, 32'd0);
        ab = iack_total;
        pulse_boundary();
        chk("R9 pending edge taken", {31'b0, busy}, 32'd1);
        wait_done("R9 pending edge done");
        chk("R9 pending vector", {16'h0, cs_val}, {16'h0, rd_model(20'h0000A)});
        chk("R2 no handshake", 32'(iack_total - ab), 32'd0);
        mem_dly = 0;

        // R11: reset mid-save discards pending edge
        intr_in = 1'b1; ie_flag = 1'b1; cfg_vec = 8'h10;
        pulse_boundary();
        intr_in = 1'b0;
        pulse_nmi();
        while (!(mem_req && mem_we)) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        chk("R11 mid busy", {31'b0, busy}, 32'd0);
        chk("R11 mid mem_req", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        pulse_boundary();
        chk("R11 pending cleared", {31'b0, busy}, 32'd0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule